// File: doc/BRIEF.md
# Log-Domain Mixture Sum Approximator

This block gives the natural log of a sum of Gaussian mixture likelihoods, working only on their log scores. For one HMM state in one frame, an upstream datapath delivers the per-mixture log terms (log weight plus exponent), one per cycle. The block keeps only the largest and the second-largest terms. It turns their gap into an index for a small correction table and adds the looked-up correction to the largest term. The output is the state's log output probability, marked by a one-cycle done pulse.

All values are signed fixed point with 15 fractional bits. The table covers the correction `ln(1 + e^A)`, where `A = (second - largest) + ln(M/2)` and M is the mixture count. The gap is shifted right to form the table index, and the table word is shifted left to return it to the score scale. Both shifts use one shared shifter whose operand is picked by a multiplexer.

Top module: `mixlog_approx`

## Requirements
- R1: After reset, `done` is 0 and `result` is 0.
- R2: `result` equals the largest accepted score plus a non-negative correction, whatever the arrival order of the scores.
- R3: A score equal to the current largest leaves the largest unchanged and becomes the second largest, so the gap is zero.
- R4: The table index is `74 + floor((second - largest) / 1024) + K`, with K = 0, 13, 22, 29, 35 for M = 2, 3, 4, 5, 6. The correction for index i is `4 * round(8192 * ln(1 + e^((i - 74) / 32)))`, within 4 LSB.
- R5: An index below 0 is clamped to entry 0. With a single score and M of 2 or more, the second largest is the most negative value and entry 0 is used.
- R6: With M of 0 or 1, the correction is exactly zero and `result` equals the largest score. M above 6 is treated as 6.
- R7: `done` goes high for exactly one cycle, on the third rising edge after the edge that accepts the score flagged last. `result` is updated on that same edge.
- R8: `start` discards all earlier scores, and a valid score in the same cycle as `start` counts as the first score. A cycle with `score_valid` low has no effect, whatever `score` carries.
- R9: `mix_count` is sampled on `start`. Changing it later in the same set has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new set of mixture scores and samples `mix_count` |
| score_valid | input | 1 | Qualifies `score` in this cycle |
| score_last | input | 1 | Marks the valid score as the final one of the set |
| score | input | 32 | Signed Q15 log score of one mixture |
| mix_count | input | 3 | Mixture count M |
| result | output | 32 | Signed Q15 approximate log of the mixture sum |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The bench targets equal scores. A tracker that promotes a tie to the maximum still gives a zero gap, so the tie test places a smaller score between the two equal ones to expose the wrong second largest. Large gaps and lone scores drive the index below the table. A missing clamp would read a wrapped entry and add a large wrong correction. Mixture counts of 0, 1 and 7 catch a design that applies a correction for a single Gaussian or indexes past the offset list. Idle cycles carrying huge scores, a mid-set restart and a `mix_count` change after `start` show up as a wrong largest or a wrong offset in `result`. The latency and pulse-width checks catch an extra or missing pipeline register.

// File: rtl/mixlog_pkg.sv
package mixlog_pkg;

    localparam int SCORE_W   = 32;
    localparam int FRAC_BITS = 15;
    localparam int M_MAX     = 6;
    localparam int MIX_W     = 3;
    localparam int LUT_DEPTH = 110;
    localparam int IDX_SHIFT = 10;
    localparam int LUT_SHIFT = 2;
    localparam int LUT_FRAC  = FRAC_BITS - LUT_SHIFT;
    localparam int LUT_W     = 14;
    localparam int IDX_W     = $clog2(LUT_DEPTH);
    localparam int DIFF_W    = SCORE_W + 1;
    localparam int FX        = 30;
    localparam longint FX_ONE = 64'sd1 <<< FX;

    typedef logic signed [SCORE_W-1:0] score_t;
    typedef logic signed [DIFF_W-1:0]  diff_t;
    typedef logic [IDX_W-1:0]          idx_t;
    typedef logic [LUT_W-1:0]          corr_t;

    typedef struct packed {
        score_t top;
        score_t next;
    } pair_t;

    typedef enum logic [1:0] {PH_IDLE, PH_INDEX, PH_CORR, PH_SUM} phase_e;

    localparam score_t SCORE_MIN = {1'b1, {(SCORE_W-1){1'b0}}};

    function automatic longint round_shift(longint v, int s);
        return (v + (64'sd1 <<< (s - 1))) >>> s;
    endfunction

    // e^x, x in Q30, Taylor series
    function automatic longint exp_fx(longint x);
        longint sum  = FX_ONE;
        longint term = FX_ONE;
        for (int n = 1; n < 40; n++) begin
            term = (term * x) >>> FX;
            term = term / n;
            sum  = sum + term;
        end
        return sum;
    endfunction

    // ln(y), y >= 1 in Q30, via 2*atanh((y-1)/(y+1))
    function automatic longint ln_fx(longint y);
        longint z    = ((y - FX_ONE) <<< FX) / (y + FX_ONE);
        longint zsq  = (z * z) >>> FX;
        longint term = z;
        longint sum  = 0;
        for (int k = 0; k < 40; k++) begin
            sum  = sum + term / (2 * k + 1);
            term = (term * zsq) >>> FX;
        end
        return 2 * sum;
    endfunction

    // ln(M/2) expressed in table steps
    function automatic int idx_offset(int m);
        if (m < 2) return 0;
        return int'(round_shift(ln_fx(longint'(m) * (FX_ONE / 2)), FX - FRAC_BITS + IDX_SHIFT));
    endfunction

    localparam int IDX_ZERO = LUT_DEPTH - 1 - idx_offset(M_MAX);

    // table word j: ln(1+e^A) at A = (j - IDX_ZERO) steps, Q(LUT_FRAC)
    function automatic longint softplus_entry(int j);
        int     jc = (j > LUT_DEPTH - 1) ? LUT_DEPTH - 1 : j;
        longint a  = longint'(jc - IDX_ZERO) <<< (FX - FRAC_BITS + IDX_SHIFT);
        return round_shift(ln_fx(FX_ONE + exp_fx(a)), FX - LUT_FRAC);
    endfunction

endpackage

// File: rtl/mixlog_tracker.sv
module mixlog_tracker
    import mixlog_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clear,
    input  logic   valid,
    input  score_t score,
    output pair_t  best
);
    pair_t base, nxt;

    always_comb begin
        base = clear ? '{top: SCORE_MIN, next: SCORE_MIN} : best;
        nxt  = base;
        if (valid) begin
            if (score > base.top) begin
                nxt.top  = score;
                nxt.next = base.top;
            end else if (score > base.next) begin
                nxt.next = score;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                best <= '{top: SCORE_MIN, next: SCORE_MIN};
        else if (clear || valid) best <= nxt;
    end

    // R2/R3: the kept maximum never falls below the runner-up
    assert_order_R2: assert property (@(posedge clk) disable iff (rst)
        best.top >= best.next);

endmodule

// File: rtl/mixlog_shifter.sv
module mixlog_shifter
    import mixlog_pkg::*;
#(
    parameter int RIGHT_AMT = IDX_SHIFT,
    parameter int LEFT_AMT  = LUT_SHIFT
) (
    input  diff_t operand,
    input  logic  go_left,
    output diff_t shifted
);
    always_comb begin
        if (go_left) shifted = operand <<< LEFT_AMT;
        else         shifted = operand >>> RIGHT_AMT;
    end
endmodule

// File: rtl/mixlog_corr_rom.sv
module mixlog_corr_rom
    import mixlog_pkg::*;
(
    input  idx_t  idx,
    output corr_t corr
);
    localparam int SLOTS = 2 ** IDX_W;

    corr_t words [SLOTS];

    for (genvar j = 0; j < SLOTS; j++) begin : g_word
        localparam longint VAL = softplus_entry(j);
        assign words[j] = corr_t'(VAL);
    end

    assign corr = words[idx];
endmodule

// File: rtl/mixlog_approx.sv
module mixlog_approx
    import mixlog_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      score_valid,
    input  logic                      score_last,
    input  logic signed [SCORE_W-1:0] score,
    input  logic [MIX_W-1:0]          mix_count,
    output logic signed [SCORE_W-1:0] result,
    output logic                      done
);
    localparam int MSLOTS = 2 ** MIX_W;

    pair_t            best;
    phase_e           phase;
    logic [MIX_W-1:0] mix_q, m_eff;
    idx_t             k_tab [MSLOTS];
    idx_t             idx_q;
    corr_t            rom_word;
    diff_t            gap, sh_in, sh_out, idx_sum;
    score_t           corr_q;
    logic             m_single;

    mixlog_tracker u_track (
        .clk   (clk),
        .rst   (rst),
        .clear (start),
        .valid (score_valid),
        .score (score),
        .best  (best)
    );

    always_ff @(posedge clk) begin
        if (rst)        mix_q <= '0;
        else if (start) mix_q <= mix_count;
    end

    assign m_eff    = (mix_q > MIX_W'(M_MAX)) ? MIX_W'(M_MAX) : mix_q;
    assign m_single = (m_eff <= MIX_W'(1));

    for (genvar m = 0; m < MSLOTS; m++) begin : g_koff
        localparam int MC = (m > M_MAX) ? M_MAX : m;
        assign k_tab[m] = idx_t'(idx_offset(MC));
    end

    // phase sequencing after the last score
    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else begin
            case (phase)
                PH_IDLE:  if (score_valid && score_last) phase <= PH_INDEX;
                PH_INDEX: phase <= PH_CORR;
                PH_CORR:  phase <= PH_SUM;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    // shared shifter: gap to the right while indexing, table word to the left after
    assign gap   = diff_t'(best.next) - diff_t'(best.top);
    assign sh_in = (phase == PH_CORR) ? diff_t'({1'b0, rom_word}) : gap;

    mixlog_shifter u_shift (
        .operand (sh_in),
        .go_left (phase == PH_CORR),
        .shifted (sh_out)
    );

    assign idx_sum = sh_out + diff_t'(IDX_ZERO) + diff_t'({1'b0, k_tab[m_eff]});

    always_ff @(posedge clk) begin
        if (rst) idx_q <= '0;
        else if (phase == PH_INDEX) begin
            if (idx_sum < 0)                            idx_q <= '0;
            else if (idx_sum > diff_t'(LUT_DEPTH - 1)) idx_q <= idx_t'(LUT_DEPTH - 1);
            else                                        idx_q <= idx_sum[IDX_W-1:0];
        end
    end

    mixlog_corr_rom u_rom (
        .idx  (idx_q),
        .corr (rom_word)
    );

    always_ff @(posedge clk) begin
        if (rst) corr_q <= '0;
        else if (phase == PH_CORR) corr_q <= m_single ? '0 : sh_out[SCORE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= (phase == PH_SUM);
            if (phase == PH_SUM) result <= best.top + corr_q;
        end
    end

    // R7: completion is a single-cycle pulse
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: the registered index never leaves the table
    assert_idx_in_table_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CORR) |-> (idx_q <= idx_t'(LUT_DEPTH - 1)));

    // R6: one mixture or fewer gives the bare maximum
    assert_single_mix_exact_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SUM && m_single) |=> (result == $past(best.top)));

    // R2: the correction never lowers the maximum
    assert_result_floor_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SUM) |=> (result >= $past(best.top)));

endmodule

// File: tb/tb_mixlog_approx.sv
module tb_mixlog_approx;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic               score_valid = 1'b0;
    logic               score_last = 1'b0;
    logic signed [31:0] score = '0;
    logic [2:0]         mix_count = '0;
    logic signed [31:0] result;
    logic               done;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    mixlog_approx dut (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .score_valid (score_valid),
        .score_last  (score_last),
        .score       (score),
        .mix_count   (mix_count),
        .result      (result),
        .done        (done)
    );

    task automatic check(string req, longint actual, longint expected, longint tol);
        longint diff = actual - expected;
        n_checks++;
        if (diff > tol || diff < -tol) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    function automatic int koff(int m);
        return $rtoi(32.0 * $ln(m / 2.0) + 0.5);
    endfunction

    // expected result from the stated rules
    function automatic longint model(int s[8], int n, int m);
        longint top = -64'sd2147483648, nxt = -64'sd2147483648;
        int     me  = (m > 6) ? 6 : m;
        longint idx;
        real    a;
        for (int i = 0; i < n; i++) begin
            if (s[i] > top) begin nxt = top; top = s[i]; end
            else if (s[i] > nxt) nxt = s[i];
        end
        if (me <= 1) return top;
        idx = 74 + longint'($floor(real'(nxt - top) / 1024.0)) + koff(me);
        if (idx < 0)   idx = 0;
        if (idx > 109) idx = 109;
        a = (idx - 74) / 32.0;
        return top + 4 * longint'($rtoi(8192.0 * $ln(1.0 + $exp(a)) + 0.5));
    endfunction

    // start cycle, then the scores; optional idle cycle with junk, optional later mix value
    task automatic send(int s[8], int n, int m, bit with_first, bit gap_junk, int mix_after);
        int first = 0;
        @(negedge clk);
        start = 1'b1; mix_count = 3'(m);
        score_valid = 1'b0; score_last = 1'b0;
        if (with_first) begin
            score_valid = 1'b1; score = s[0]; score_last = (n == 1); first = 1;
        end
        for (int i = first; i < n; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (mix_after >= 0) mix_count = 3'(mix_after);
            if (gap_junk && i == 1) begin
                score_valid = 1'b0; score = 32'sh7fff0000; score_last = 1'b1;
                @(negedge clk);
            end
            score_valid = 1'b1; score = s[i]; score_last = (i == n - 1);
        end
        @(negedge clk);
        start = 1'b0; score_valid = 1'b0; score_last = 1'b0; score = '0;
    endtask

    task automatic await_result(string req, longint expected);
        int c = 1;
        while (!done && c < 20) begin
            @(negedge clk);
            c++;
        end
        check({req, " R7 latency"}, c, 4, 0);
        check(req, result, expected, 4);
        @(negedge clk);
        check({req, " R7 pulse width"}, done, 0, 0);
        check({req, " R7 result held"}, result, expected, 4);
    endtask

    task automatic t_reset();
        check("R1 done after reset", done, 0, 0);
        check("R1 result after reset", result, 0, 0);
    endtask

    task automatic t_ascending();
        int s[8] = '{-50000, -40000, -30000, -20000, 0, 0, 0, 0};
        send(s, 4, 4, 1'b0, 1'b0, -1);
        await_result("R2 R4 ascending M=4", model(s, 4, 4));
    endtask

    task automatic t_mixed_order();
        int s[8] = '{-10000, -90000, -12000, -70000, -15000, -80000, 0, 0};
        send(s, 6, 6, 1'b0, 1'b0, -1);
        await_result("R2 R4 mixed order M=6", model(s, 6, 6));
    endtask

    task automatic t_ties();
        int s[8] = '{-5000, -5000, 0, 0, 0, 0, 0, 0};
        int u[8] = '{-3000, -8000, -3000, 0, 0, 0, 0, 0};
        send(s, 2, 2, 1'b0, 1'b0, -1);
        await_result("R3 equal pair M=2", -5000 + 22712);
        send(u, 3, 3, 1'b0, 1'b0, -1);
        await_result("R3 tie after smaller M=3", model(u, 3, 3));
    endtask

    task automatic t_clamp();
        int s[8] = '{0, -200000, 0, 0, 0, 0, 0, 0};
        int u[8] = '{-7000, 0, 0, 0, 0, 0, 0, 0};
        send(s, 2, 2, 1'b0, 1'b0, -1);
        await_result("R5 wide gap clamps low", model(s, 2, 2));
        send(u, 1, 3, 1'b0, 1'b0, -1);
        await_result("R5 single score", model(u, 1, 3));
    endtask

    task automatic t_mix_limits();
        int s[8] = '{-1000, -900, 0, 0, 0, 0, 0, 0};
        int u[8] = '{-1000, -1000, 0, 0, 0, 0, 0, 0};
        send(s, 2, 1, 1'b0, 1'b0, -1);
        await_result("R6 M=1 exact max", -900);
        send(s, 2, 0, 1'b0, 1'b0, -1);
        await_result("R6 M=0 exact max", -900);
        send(u, 2, 7, 1'b0, 1'b0, -1);
        await_result("R6 M=7 as 6", model(u, 2, 6));
    endtask

    task automatic t_idle_junk();
        int s[8] = '{-20000, -26000, -21000, 0, 0, 0, 0, 0};
        send(s, 3, 5, 1'b0, 1'b1, -1);
        await_result("R8 idle cycle ignored", model(s, 3, 5));
    endtask

    task automatic t_restart();
        int p[8] = '{100000, 90000, 0, 0, 0, 0, 0, 0};
        int s[8] = '{-40000, -41000, 0, 0, 0, 0, 0, 0};
        @(negedge clk);
        start = 1'b1; mix_count = 3'd4;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            start = 1'b0; score_valid = 1'b1; score = p[i]; score_last = 1'b0;
        end
        send(s, 2, 4, 1'b1, 1'b0, -1);
        await_result("R8 restart with first score", model(s, 2, 4));
    endtask

    task automatic t_mix_sample();
        int s[8] = '{-30000, -31000, -35000, 0, 0, 0, 0, 0};
        send(s, 3, 6, 1'b0, 1'b0, 1);
        await_result("R9 mix sampled at start", model(s, 3, 6));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R7 watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ascending();
        t_mixed_order();
        t_ties();
        t_clamp();
        t_mix_limits();
        t_idle_junk();
        t_restart();
        t_mix_sample();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule